// File: doc/BRIEF.md
# Wide-to-Narrow Endian-Selectable Bus Adapter

The block sits between a 36-bit FIFO and an 18-bit external bus, once in each direction. On the transmit side it takes one 36-bit entry from the FIFO over a valid/ready handshake. It then hands that entry out as a series of narrow parts on the bus. On the receive side it gathers narrow parts from the bus and assembles them into 36-bit entries, which it offers to the FIFO over a valid/ready handshake.

The narrow bus works in one of two sizes. In word size each part is 18 bits, so an entry takes two parts. In byte size each part is 9 bits on the low lanes, so an entry takes four parts. Part order is either most-significant-first or least-significant-first. Both size and order are captured while reset is held and stay fixed until the next reset. Every narrow transfer is qualified by an enable and completes on the rising clock edge.

Top module: `nbus_width_adapter`

## Requirements
- R1: While and right after reset, `tx_vld` and `out_valid` are 0 and `in_ready` is 1.
- R2: `cfg_byte` and `cfg_order` are sampled only while `rst_n` is low. Changes to them after reset has been released have no effect on the data on either side.
- R3: When `cfg_byte`=0 (word size), an entry goes out as two 18-bit parts. When `cfg_byte`=1 (byte size), it goes out as four 9-bit parts on `tx_data[8:0]`, and `tx_data[17:9]` is 0.
- R4: When `cfg_order`=1, parts are sent most significant first (word: bits 35:18 then 17:0; byte: 35:27, 26:18, 17:9, 8:0). When `cfg_order`=0, the order is reversed, starting with the lowest part.
- R5: A new entry is taken (`in_valid` && `in_ready`) only when no part is pending or the last part of the current entry is transferring. `in_ready` is 0 whenever `tx_vld` is 1 and `tx_en` is 0.
- R6: A narrow transmit transfer happens on a rising edge where `tx_vld` and `tx_en` are both 1. While `tx_en` is 0, `tx_vld` and `tx_data` hold.
- R7: The receive side places incoming parts using the same size and order as R3 and R4. A part stream from the transmit side therefore comes back out on `out_data` as the original entry.
- R8: When `out_valid`=1 and `out_ready`=0, `out_valid` and `out_data` hold, and `rx_ready` is 0.
- R9: `rx_data` is ignored on any edge where `rx_en` or `rx_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; mode is captured while it is low |
| cfg_byte | input | 1 | 1 = 9-bit parts, 0 = 18-bit parts |
| cfg_order | input | 1 | 1 = most significant part first, 0 = least significant first |
| in_valid | input | 1 | FIFO offers an entry to transmit |
| in_ready | output | 1 | Adapter takes the offered entry |
| in_data | input | 36 | Entry to transmit |
| tx_vld | output | 1 | A transmit part is present |
| tx_en | input | 1 | Bus enable; part transfers on the edge |
| tx_data | output | 18 | Transmit part |
| rx_en | input | 1 | Receive part present on the bus |
| rx_ready | output | 1 | Adapter can accept a receive part |
| rx_data | input | 18 | Receive part |
| out_valid | output | 1 | An assembled entry is offered to the FIFO |
| out_ready | input | 1 | FIFO accepts the assembled entry |
| out_data | output | 36 | Assembled entry |

## Verification
The hardest case to reach is a transmit entry that finishes its last part in the same cycle that a new entry is popped, while the receive side is held off by a full output slot. That chain of backpressure has to reach back through `rx_ready` into the bus enable. The stimulus loops the transmit bus into the receive bus and gates the enable at random. It also runs one pass with `out_ready` mostly low and another with it always high. Together these produce long stalls and back-to-back pops in every size and order, while the mode pins toggle after reset to show they are ignored.

// File: rtl/nbus_width_adapter.sv
module nbus_width_adapter #(
  parameter int NW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_byte,
  input  logic          cfg_order,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2*NW-1:0] in_data,
  output logic          tx_vld,
  input  logic          tx_en,
  output logic [NW-1:0] tx_data,
  input  logic          rx_en,
  output logic          rx_ready,
  input  logic [NW-1:0] rx_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2*NW-1:0] out_data
);
  localparam int WW = 2 * NW;
  localparam int BW = NW / 2;

  logic byte_q, big_q;
  always_ff @(posedge clk)
    if (!rst_n) begin
      byte_q <= cfg_byte;
      big_q  <= cfg_order;
    end

  logic [1:0] last_k;
  assign last_k = byte_q ? 2'd3 : 2'd1;

  logic [WW-1:0] hold;
  logic          full;
  logic [1:0]    tk, tj;
  logic          tx_last, tx_fire;

  assign tj       = big_q ? last_k - tk : tk;
  assign tx_last  = (tk == last_k);
  assign tx_fire  = full && tx_en;
  assign tx_vld   = full;
  assign in_ready = !full || (tx_fire && tx_last);
  assign tx_data  = byte_q ? {{(NW-BW){1'b0}}, hold[int'(tj)*BW +: BW]}
                           : hold[int'(tj[0])*NW +: NW];

  always_ff @(posedge clk)
    if (!rst_n) begin
      full <= 1'b0;
      tk   <= '0;
      hold <= '0;
    end else begin
      if (tx_fire) tk <= tx_last ? 2'd0 : tk + 2'd1;
      if (in_valid && in_ready) begin
        hold <= in_data;
        full <= 1'b1;
      end else if (tx_fire && tx_last) begin
        full <= 1'b0;
      end
    end

  logic [WW-1:0] acc, merged;
  logic [1:0]    rk, rj;
  logic          rx_last, rx_fire;

  assign rj       = big_q ? last_k - rk : rk;
  assign rx_last  = (rk == last_k);
  assign rx_ready = !out_valid || out_ready;
  assign rx_fire  = rx_en && rx_ready;

  always_comb begin
    merged = acc;
    if (byte_q) merged[int'(rj)*BW +: BW] = rx_data[BW-1:0];
    else        merged[int'(rj[0])*NW +: NW] = rx_data;
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      acc       <= '0;
      rk        <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (rx_fire) begin
        acc <= merged;
        rk  <= rx_last ? 2'd0 : rk + 2'd1;
      end
      if (rx_fire && rx_last) begin
        out_data  <= merged;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
endmodule

module nbus_width_adapter_chk #(
  parameter int NW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          byte_q,
  input logic          in_ready,
  input logic          tx_vld,
  input logic          tx_en,
  input logic [NW-1:0] tx_data,
  input logic          rx_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [2*NW-1:0] out_data
);
  assert_mode_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(byte_q));
  assert_byte_high_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_vld && byte_q) |-> (tx_data[NW-1:NW/2] == '0));
  assert_no_early_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_vld && !tx_en) |-> !in_ready);
  assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_vld && !tx_en) |=> (tx_vld && $stable(tx_data)));
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  assert_rx_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !rx_ready);
endmodule

bind nbus_width_adapter nbus_width_adapter_chk #(.NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_q(byte_q), .in_ready(in_ready),
  .tx_vld(tx_vld), .tx_en(tx_en), .tx_data(tx_data), .rx_ready(rx_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/sim_nbus_width_adapter.sv
module sim_nbus_width_adapter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_byte = 1'b0, cfg_order = 1'b0;
  logic        in_valid = 1'b0;
  logic [35:0] in_data = '0;
  logic        gate = 1'b0, out_ready = 1'b0;
  logic [17:0] junk = '0;
  logic        in_ready, tx_vld, rx_ready, out_valid, tx_en, rx_en;
  logic [17:0] tx_data, rx_data;
  logic [35:0] out_data;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  assign tx_en   = gate && rx_ready;
  assign rx_en   = tx_vld && tx_en;
  assign rx_data = rx_en ? tx_data : junk;

  nbus_width_adapter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte), .cfg_order(cfg_order),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .tx_vld(tx_vld), .tx_en(tx_en), .tx_data(tx_data),
    .rx_en(rx_en), .rx_ready(rx_ready), .rx_data(rx_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] exp_part(logic [35:0] w, bit b, bit g, int k);
    int n = b ? 4 : 2;
    int j = g ? n - 1 - k : k;
    logic [35:0] s;
    if (b) begin s = w >> (9 * j);  return {9'd0, s[8:0]}; end
    s = w >> (18 * j);
    return s[17:0];
  endfunction

  task automatic run_mode(bit b, bit g, int nw, int stall_pct, bit toggle_cfg);
    logic [35:0] words [0:63];
    int sent = 0, txw = 0, txk = 0, got = 0, cyc = 0;
    bit prev_tx_stall = 0, prev_out_stall = 0;
    logic [17:0] prev_tx;
    logic [35:0] prev_out;
    for (int i = 0; i < nw; i++) words[i] = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
    words[0] = 36'hA_BCDE_F012;
    @(negedge clk);
    cfg_byte = b; cfg_order = g; rst_n = 1'b0;
    in_valid = 0; gate = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 tx_vld", {35'd0, tx_vld}, 36'd0);
    chk("R1 out_valid", {35'd0, out_valid}, 36'd0);
    chk("R1 in_ready", {35'd0, in_ready}, 36'd1);
    @(negedge clk);
    rst_n = 1'b1;
    while (got < nw && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (prev_tx_stall) begin
        chk("R6 tx_vld hold", {35'd0, tx_vld}, 36'd1);
        chk("R6 tx_data hold", {18'd0, tx_data}, {18'd0, prev_tx});
      end
      if (prev_out_stall) begin
        chk("R8 out_valid hold", {35'd0, out_valid}, 36'd1);
        chk("R8 out_data hold", out_data, prev_out);
      end
      if (toggle_cfg) begin cfg_byte = $urandom; cfg_order = $urandom; end
      in_valid  = (sent < nw);
      in_data   = (sent < nw) ? words[sent] : 36'd0;
      gate      = ($urandom % 100) >= 30;
      out_ready = ($urandom % 100) >= stall_pct;
      junk      = $urandom;
      #1;
      if (tx_vld && !tx_en) chk("R5 no pop while part pending", {35'd0, in_ready}, 36'd0);
      if (tx_vld && tx_en) begin
        chk("R3 R4 R2 tx part", {18'd0, tx_data}, {18'd0, exp_part(words[txw], b, g, txk)});
        if (txk == (b ? 3 : 1)) begin txk = 0; txw++; end else txk++;
      end
      if (out_valid && out_ready) begin
        chk("R7 R9 round trip", out_data, words[got]);
        got++;
      end
      if (out_valid && !out_ready) chk("R8 rx_ready low", {35'd0, rx_ready}, 36'd0);
      if (in_valid && in_ready) sent++;
      prev_tx_stall  = tx_vld && !tx_en;
      prev_tx        = tx_data;
      prev_out_stall = out_valid && !out_ready;
      prev_out       = out_data;
    end
    chk("R7 all entries returned", 36'(got), 36'(nw));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int m = 0; m < 4; m++) run_mode(m[1], m[0], 40, 20, 1);
    run_mode(1, 1, 20, 90, 0);
    run_mode(0, 0, 20, 0, 0);
    run_mode(1, 0, 20, 0, 1);
    run_mode(0, 1, 20, 90, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule